// File: doc/BRIEF.md
# Serial Configuration Receiver with Chain Forwarding

This block takes in a configuration stream one bit at a time and keeps the first `IMG_BITS` bits as its own image, in an internal register array that is shown on a parallel output. Once the image is full, the block becomes a relay. Every later bit it receives is sent on through a registered serial output, so that a second receiver wired behind it can load its own image from the same stream.

The stream can be clocked in two ways, and a 3-bit mode input picks one:

- **Slave mode.** A configuration clock comes in from outside. Its rising edges are found in the system clock domain.
- **Master mode.** The block makes the configuration clock itself, using a counter divider, and drives it out. The divider always starts at its slowest rate. A 2-bit rate field placed at a fixed position inside the image then speeds the clock up for the rest of the load.

A synchronous active-low program input restarts a load.

Top module: `serial_cfg_rx`

## Requirements
- R1: With mode 3'b111 (slave), one bit of `din` is taken at each rising edge of `ext_cclk`. A level held high for several cycles counts as one edge. The k-th bit taken since the last program pulse is stored at `image[k]`.
- R2: In slave mode `cclk_oe` is 0 and `cclk_out` stays low. With mode 3'b110 (master), `cclk_oe` is 1, `cclk_out` toggles, and one bit of `din` is taken in the cycle where `cclk_out` goes from low to high.
- R3: In master mode, after reset or a program pulse, each half period of `cclk_out` lasts `SLOW_HALF` system clock cycles, so a full period is 2*`SLOW_HALF` cycles.
- R4: The two image bits at positions RATE_POS+1 (msb) and RATE_POS (lsb) form a rate select s. From the `cclk_out` rising edge that takes bit RATE_POS+1 onward, the half period is max(1, `SLOW_HALF` >> s) cycles. The rate select changes only when a bit is taken.
- R5: `done` is low until bit `IMG_BITS`-1 has been taken. It is high from that cycle on, until the next program pulse.
- R6: `dout` is 0 while `done` is low. After `done` rises, each further bit taken appears on `dout` in the cycle after it is sampled. `image` is not changed by any further bit.
- R7: Any mode value other than 3'b111 and 3'b110 takes no bits and leaves `cclk_oe` low, whatever `ext_cclk` does.
- R8: `prog_n` low at a clock edge clears the bit count, `done`, `dout` and the rate select, and restarts the divider at its slow rate. `image` keeps its contents until it is overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_n | input | 1 | Synchronous active-low restart of a load |
| mode | input | 3 | Clocking mode: 3'b111 slave, 3'b110 master, other values idle |
| ext_cclk | input | 1 | External configuration clock (slave mode) |
| din | input | 1 | Serial configuration data |
| cclk_out | output | 1 | Generated configuration clock (master mode) |
| cclk_oe | output | 1 | High when `cclk_out` should drive the clock line |
| dout | output | 1 | Chain output to the next receiver |
| done | output | 1 | Own image fully loaded |
| image | output | IMG_BITS | Stored configuration image, bit k = k-th bit received |

## Verification
The assertions check on every cycle the rules that hold at any moment:

- `dout` stays low before `done`, and `done` stays set until a program pulse.
- The image is frozen once `done` is set.
- The rate select moves only on a taken bit.
- Idle modes take no bits.
- A program pulse clears the load state.
- The generated clock is high after a master-mode take, and is released when master mode is left.

Only the bench scenarios can show the rest:

- The bit order inside the image.
- The exact number of bits before `done`.
- The one-cycle lag of the forwarded data.
- The measured clock periods before and after the rate field, for every rate select.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  localparam logic [2:0] MODE_SLAVE_SERIAL  = 3'b111;
  localparam logic [2:0] MODE_MASTER_SERIAL = 3'b110;

  // Half period of the generated clock, in system clock cycles.
  function automatic int unsigned half_cycles(int unsigned slow_half, logic [1:0] sel);
    int unsigned h;
    h = slow_half >> sel;
    return (h == 0) ? 1 : h;
  endfunction

endpackage

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen
  import serial_cfg_pkg::*;
#(
  parameter int SLOW_HALF = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_n,
  input  logic       master_en,
  input  logic       slave_en,
  input  logic       ext_cclk,
  input  logic [1:0] rate_sel,
  output logic       cclk_q,
  output logic       edge_seen
);
  localparam int DIV_W = $clog2(SLOW_HALF + 1);

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_lim;
  logic             ext_prev;
  logic             tick;
  logic             slave_rise;
  logic             master_rise;

  always_comb begin
    div_lim     = DIV_W'(half_cycles(SLOW_HALF, rate_sel) - 1);
    tick        = master_en && (div_cnt >= div_lim);
    master_rise = tick && !cclk_q;
    slave_rise  = slave_en && ext_cclk && !ext_prev;
    edge_seen   = slave_rise || master_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev <= 1'b0;
    end else begin
      ext_prev <= ext_cclk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      cclk_q  <= 1'b0;
    end else if (!prog_n || !master_en) begin
      div_cnt <= '0;
      cclk_q  <= 1'b0;
    end else if (tick) begin
      div_cnt <= '0;
      cclk_q  <= !cclk_q;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cfg_image_store.sv
module cfg_image_store #(
  parameter int IMG_BITS = 32,
  parameter int RATE_POS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prog_n,
  input  logic                take,
  input  logic                din,
  output logic [IMG_BITS-1:0] image,
  output logic                done,
  output logic [1:0]          rate_sel
);
  localparam int CNT_W = $clog2(IMG_BITS + 1);

  logic [CNT_W-1:0]    bit_cnt;
  logic                wr_en;
  logic [IMG_BITS-1:0] hit;

  assign wr_en = take && !done;

  // One-hot decode of the write position.
  for (genvar i = 0; i < IMG_BITS; i++) begin : g_hit
    assign hit[i] = wr_en && (bit_cnt == CNT_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      image <= '0;
    end else begin
      for (int i = 0; i < IMG_BITS; i++) begin
        if (hit[i]) image[i] <= din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      done     <= 1'b0;
      rate_sel <= 2'b00;
    end else if (!prog_n) begin
      bit_cnt  <= '0;
      done     <= 1'b0;
      rate_sel <= 2'b00;
    end else if (wr_en) begin
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == CNT_W'(IMG_BITS - 1)) done <= 1'b1;
      if (bit_cnt == CNT_W'(RATE_POS + 1)) rate_sel <= {din, image[RATE_POS]};
    end
  end

endmodule

// File: rtl/cfg_chain_out.sv
module cfg_chain_out (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_n,
  input  logic take,
  input  logic done,
  input  logic din,
  output logic dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= 1'b0;
    end else if (!prog_n) begin
      dout <= 1'b0;
    end else if (take) begin
      dout <= done ? din : 1'b0;
    end
  end
endmodule

// File: rtl/serial_cfg_rx.sv
module serial_cfg_rx
  import serial_cfg_pkg::*;
#(
  parameter int IMG_BITS  = 32,
  parameter int RATE_POS  = 4,
  parameter int SLOW_HALF = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prog_n,
  input  logic [2:0]          mode,
  input  logic                ext_cclk,
  input  logic                din,
  output logic                cclk_out,
  output logic                cclk_oe,
  output logic                dout,
  output logic                done,
  output logic [IMG_BITS-1:0] image
);
  logic       slave_en;
  logic       master_en;
  logic       edge_seen;
  logic       take;
  logic       cclk_q;
  logic [1:0] rate_sel;

  assign slave_en  = (mode == MODE_SLAVE_SERIAL);
  assign master_en = (mode == MODE_MASTER_SERIAL);
  assign take      = prog_n && edge_seen;
  assign cclk_oe   = master_en;
  assign cclk_out  = cclk_q;

  cfg_clk_gen #(.SLOW_HALF(SLOW_HALF)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_n    (prog_n),
    .master_en (master_en),
    .slave_en  (slave_en),
    .ext_cclk  (ext_cclk),
    .rate_sel  (rate_sel),
    .cclk_q    (cclk_q),
    .edge_seen (edge_seen)
  );

  cfg_image_store #(.IMG_BITS(IMG_BITS), .RATE_POS(RATE_POS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_n   (prog_n),
    .take     (take),
    .din      (din),
    .image    (image),
    .done     (done),
    .rate_sel (rate_sel)
  );

  cfg_chain_out u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .prog_n (prog_n),
    .take   (take),
    .done   (done),
    .din    (din),
    .dout   (dout)
  );

endmodule

// File: rtl/serial_cfg_rx_chk.sv
module serial_cfg_rx_chk #(
  parameter int IMG_BITS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                prog_n,
  input logic [2:0]          mode,
  input logic                take,
  input logic                done,
  input logic                dout,
  input logic                cclk_out,
  input logic                cclk_oe,
  input logic [IMG_BITS-1:0] image,
  input logic [1:0]          rate_sel
);

  assert_dout_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !dout);

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && prog_n) |=> done);

  assert_image_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && prog_n) |=> $stable(image));

  assert_prog_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |=> (!done && !dout && rate_sel == 2'b00));

  assert_rate_on_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && prog_n) |=> $stable(rate_sel));

  assert_idle_no_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'b111 && mode != 3'b110) |-> (!take && !cclk_oe));

  assert_master_take_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cclk_oe) |=> (cclk_out || !cclk_oe));

  assert_clock_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cclk_oe |=> (cclk_oe || !cclk_out));

endmodule

bind serial_cfg_rx serial_cfg_rx_chk #(.IMG_BITS(IMG_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .prog_n   (prog_n),
  .mode     (mode),
  .take     (take),
  .done     (done),
  .dout     (dout),
  .cclk_out (cclk_out),
  .cclk_oe  (cclk_oe),
  .image    (image),
  .rate_sel (rate_sel)
);

// File: tb/tb_serial_cfg_rx.sv
module tb_serial_cfg_rx;
  localparam int IMG = 12;
  localparam int RP  = 2;
  localparam int SH  = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           prog_n = 1'b1;
  logic [2:0]     mode = 3'b111;
  logic           ext_cclk = 1'b0;
  logic           din = 1'b0;
  logic           cclk_out, cclk_oe, dout, done;
  logic [IMG-1:0] image;

  int n_tests = 0;
  int n_fail  = 0;

  serial_cfg_rx #(.IMG_BITS(IMG), .RATE_POS(RP), .SLOW_HALF(SH)) dut (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .mode(mode),
    .ext_cclk(ext_cclk), .din(din), .cclk_out(cclk_out), .cclk_oe(cclk_oe),
    .dout(dout), .done(done), .image(image)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_prog();
    @(negedge clk); prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1;
  endtask

  // One external clock pulse, with the given number of high cycles.
  task automatic slave_bit(input logic b, input int high_cycles);
    @(negedge clk); din = b; ext_cclk = 1'b1;
    repeat (high_cycles) @(negedge clk);
    ext_cclk = 1'b0;
    @(negedge clk);
  endtask

  function automatic int exp_period(int s);
    int h;
    h = SH >> s;
    if (h == 0) h = 1;
    return 2 * h;
  endfunction

  // Slave load of one image plus a forwarded tail.
  task automatic slave_run(input logic [IMG-1:0] p, input logic [7:0] f);
    do_prog();
    for (int i = 0; i < IMG; i++) begin
      slave_bit(p[i], 1);
      if (i == IMG - 2) chk("R5", "done before last bit", done, 0);
      if (i == IMG - 1) chk("R6", "dout before pass-through", dout, 0);
    end
    chk("R5", "done after last bit", done, 1);
    chk("R1", "image order", image, p);
    for (int k = 0; k < 8; k++) begin
      slave_bit(f[k], 1);
      chk("R6", "forwarded bit", dout, f[k]);
    end
    chk("R6", "image frozen", image, p);
  endtask

  // Master load: the bench follows the generated clock.
  task automatic master_run(input logic [IMG-1:0] p, input int s, input logic [7:0] f);
    int idx, cyc, last;
    logic prev;
    mode = 3'b110;
    din = p[0];
    do_prog();
    idx = 0; cyc = 0; last = -1; prev = cclk_out;
    while (idx < IMG + 8) begin
      @(negedge clk);
      cyc++;
      if (cclk_out && !prev) begin
        if (last >= 0) begin
          if (idx - 1 >= RP + 1)
            chk("R4", $sformatf("period s=%0d", s), cyc - last, exp_period(s));
          else
            chk("R3", "slow period", cyc - last, 2 * SH);
        end
        if (idx == IMG - 2) chk("R5", "master done early", done, 0);
        if (idx == IMG - 1) chk("R5", "master done", done, 1);
        if (idx >= IMG) chk("R6", "master forwarded bit", dout, f[idx-IMG]);
        last = cyc;
        idx++;
        din = (idx < IMG) ? p[idx] : f[(idx < IMG + 8) ? idx - IMG : 0];
      end
      prev = cclk_out;
    end
    chk("R1", "master image order", image, p);
    chk("R2", "master output enable", cclk_oe, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [IMG-1:0] p;
    int tog;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state.
    chk("R5", "reset done", done, 0);
    chk("R6", "reset dout", dout, 0);
    chk("R1", "reset image", image, 0);

    // Slave clock pins.
    repeat (20) @(negedge clk);
    chk("R2", "slave oe", cclk_oe, 0);
    chk("R2", "slave clock low", cclk_out, 0);

    // Slave pattern sweep.
    slave_run(12'h000, 8'hA5);
    slave_run(12'hFFF, 8'h0F);
    for (int v = 0; v < 16; v++) begin
      p = IMG'((v * 12'h2D7) ^ {v[3:0], v[3:0], v[3:0]});
      slave_run(p, 8'(v * 8'h3B));
    end

    // A held high level is one edge.
    do_prog();
    slave_bit(1'b1, 4);
    chk("R1", "held level one bit", image[0], 1);
    p = 12'h6C9;
    for (int i = 1; i < IMG; i++) begin
      slave_bit(p[i], 1);
      if (i == IMG - 2) chk("R1", "count after held level", done, 0);
    end
    chk("R1", "done after held level", done, 1);
    chk("R1", "image after held level", image, {p[IMG-1:1], 1'b1});

    // Idle modes take nothing.
    for (int m = 0; m < 6; m++) begin
      mode = 3'(m);
      do_prog();
      for (int t = 0; t < 5; t++) slave_bit(1'b1, 1);
      chk("R7", $sformatf("idle mode %0d done", m), done, 0);
      chk("R7", $sformatf("idle mode %0d oe", m), cclk_oe, 0);
      mode = 3'b111;
      p = IMG'(12'h935 ^ m);
      for (int i = 0; i < IMG; i++) begin
        slave_bit(p[i], 1);
        if (i == IMG - 2) chk("R7", "no stray bits", done, 0);
      end
      chk("R7", "image after idle", image, p);
    end

    // Master loads over every rate select.
    for (int s = 0; s < 4; s++) begin
      p = 12'hB3B;
      p[RP]   = s[0];
      p[RP+1] = s[1];
      master_run(p, s, 8'(8'h5C + s));
    end

    // Program pulse restarts at the slow rate.
    do_prog();
    chk("R8", "prog done", done, 0);
    chk("R8", "prog dout", dout, 0);
    begin
      int cyc, r1, r2;
      logic prev;
      cyc = 0; r1 = -1; r2 = -1; prev = cclk_out; tog = 0;
      while (r2 < 0 && cyc < 200) begin
        @(negedge clk);
        cyc++;
        if (cclk_out && !prev) begin
          if (r1 < 0) r1 = cyc; else r2 = cyc;
        end
        prev = cclk_out;
      end
      chk("R8", "period after prog", r2 - r1, 2 * SH);
    end
    chk("R8", "image kept", image[IMG-1:RP+2], 12'hB3B >> (RP + 2));

    mode = 3'b111;
    @(negedge clk);
    chk("R2", "clock released", cclk_out, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule